// File: doc/BRIEF.md
# Configuration image integrity checker

The block watches a configuration image as it is written, one 32-bit word at a time, into a fixed window of word addresses. The first word of the window must carry the device identifier that the block was built with. The last word written must be a CRC-32 over every byte that came before it. Words the uploader marks as table-header CRC locations must hold the CRC of the table that precedes them. When the uploader pulses the end-of-image strobe, the block fixes four status flags: an overall-valid flag and three separate error flags. Software reads them back at a status word address.

A cold-reset command clears the flags. It also restarts both CRC accumulators and returns the block to programming mode, so a fresh image can be loaded. The checker does not parse the individual tables; it only checks the identifier and the CRCs.

Top module: `cfg_image_checker`

## Requirements
- R1: After rst_ni is released, a read of the status address returns 0.
- R2: If the word written to the window base address (0x020000) differs from parameter DEV_ID, then after the end strobe status bit 29 (identifier mismatch) is 1.
- R3: The CRC-32 is reflected, uses polynomial 0xEDB88320, starts from all ones and is inverted at the end. Each word is fed least significant byte first. If the last in-window word differs from the CRC of all earlier in-window words, then after the end strobe status bit 28 (global CRC error) is 1.
- R4: A write with hdr_crc_i=1 compares its data with the inverted CRC of the words since the start of the image or since the previous header word, whichever is later. The header word itself belongs to no table. A mismatch makes status bit 30 (local CRC error) 1 after the end strobe.
- R5: After the end strobe, status bit 31 (valid) is 1 exactly when bits 30, 29 and 28 are all 0. Bits 27..0 always read 0.
- R6: The status word is read at rd_addr_i = 1. Any other read address returns 0.
- R7: Writes outside the window [0x020000, 0x020000+WIN_WORDS) have no effect on the result.
- R8: The flags appear in the cycle after the end strobe and read 0 before it. Once set, they hold until a cold reset. Writes and strobes after that point, and writes in the same cycle as a strobe, are ignored.
- R9: A cold_rst_i pulse clears all flags and re-arms the checker, so the next image is judged on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Word write strobe |
| wr_addr_i | input | ADDR_W | Word address of the write |
| wr_data_i | input | 32 | Write data |
| hdr_crc_i | input | 1 | Marks the write as a table-header CRC word |
| eoi_i | input | 1 | End-of-image strobe |
| cold_rst_i | input | 1 | Cold reset: clear status, re-arm |
| rd_addr_i | input | ADDR_W | Status read address |
| rd_data_o | output | 32 | Read data |

## Verification
The bench builds the block with WIN_WORDS=40, so an address just above the window can be reached. At that size, random images of up to 32 words fit inside the window, while stray writes land both below and above it. The default DEV_ID is kept, and images are built with a wrong identifier, a bad header CRC, a bad trailing CRC or any mix of these. This drives every combination of the four flags.

// File: rtl/cfg_chk_pkg.sv
package cfg_chk_pkg;
  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

  // reflected CRC over one word, LSB first
  function automatic logic [31:0] crc32_word(input logic [31:0] crc, input logic [31:0] data);
    logic [31:0] c;
    c = crc;
    for (int i = 0; i < 32; i++) begin
      if (c[0] ^ data[i]) c = (c >> 1) ^ CRC_POLY;
      else                c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/cfg_crc_acc.sv
module cfg_crc_acc
  import cfg_chk_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [31:0] data_i,
  output logic [31:0] crc_o
);
  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= CRC_INIT;
    else if (clr_i) crc_q <= CRC_INIT;
    else if (en_i)  crc_q <= crc32_word(crc_q, data_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/cfg_win_decode.sv
module cfg_win_decode #(
  parameter int unsigned ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] BASE = 24'h02_0000,
  parameter int unsigned WIN_WORDS = 4096
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_win_o,
  output logic              first_o
);
  localparam logic [ADDR_W:0] LO = {1'b0, BASE};
  localparam logic [ADDR_W:0] HI = LO + (ADDR_W+1)'(WIN_WORDS);

  logic [ADDR_W:0] a_ext;
  assign a_ext    = {1'b0, addr_i};
  assign in_win_o = (a_ext >= LO) && (a_ext < HI);
  assign first_o  = (addr_i == BASE);
endmodule

// File: rtl/cfg_status_reg.sv
module cfg_status_reg #(
  parameter int unsigned ADDR_W = 24,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 24'h1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cold_i,
  input  logic              fire_i,
  input  logic              id_err_i,
  input  logic              lcrc_err_i,
  input  logic              gcrc_err_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              done_o,
  output logic [31:0]       rd_data_o
);
  // {valid, local crc, id mismatch, global crc}
  logic [3:0] flags_q;
  logic       done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      done_q  <= 1'b0;
    end else if (cold_i) begin
      flags_q <= '0;
      done_q  <= 1'b0;
    end else if (fire_i) begin
      flags_q <= {~(id_err_i | lcrc_err_i | gcrc_err_i), lcrc_err_i, id_err_i, gcrc_err_i};
      done_q  <= 1'b1;
    end
  end

  assign done_o    = done_q;
  assign rd_data_o = (rd_addr_i == STATUS_ADDR) ? {flags_q, 28'h0} : 32'h0;

  p_cold_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cold_i |=> (flags_q == 4'h0) && !done_q);
  p_hold_after_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !cold_i) |=> $stable(flags_q) && done_q);
  p_one_outcome_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> (flags_q[3] ^ (|flags_q[2:0])));
  p_clear_before_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q |-> (flags_q == 4'h0));
endmodule

// File: rtl/cfg_image_checker.sv
module cfg_image_checker
  import cfg_chk_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter logic [ADDR_W-1:0] BASE = 24'h02_0000,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 24'h1,
  parameter int unsigned WIN_WORDS = 4096,
  parameter logic [31:0] DEV_ID = 32'h5A17_C0DE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              hdr_crc_i,
  input  logic              eoi_i,
  input  logic              cold_rst_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o
);
  logic        in_win, first, done, acc_we, fire;
  logic [31:0] glob_crc, tbl_crc, crc_before_last, last_word;
  logic        id_ok_q, lcrc_q;

  cfg_win_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .WIN_WORDS(WIN_WORDS)) u_dec (
    .addr_i(wr_addr_i), .in_win_o(in_win), .first_o(first)
  );

  assign acc_we = wr_valid_i & in_win & ~done & ~cold_rst_i & ~eoi_i;
  assign fire   = eoi_i & ~done & ~cold_rst_i;

  cfg_crc_acc u_glob (
    .clk_i, .rst_ni, .clr_i(cold_rst_i), .en_i(acc_we), .data_i(wr_data_i), .crc_o(glob_crc)
  );

  // header word restarts the per-table CRC and is itself not part of any table
  cfg_crc_acc u_tbl (
    .clk_i, .rst_ni, .clr_i(cold_rst_i | (acc_we & hdr_crc_i)), .en_i(acc_we),
    .data_i(wr_data_i), .crc_o(tbl_crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_ok_q         <= 1'b0;
      lcrc_q          <= 1'b0;
      crc_before_last <= CRC_INIT;
      last_word       <= '0;
    end else if (cold_rst_i) begin
      id_ok_q         <= 1'b0;
      lcrc_q          <= 1'b0;
      crc_before_last <= CRC_INIT;
      last_word       <= '0;
    end else if (acc_we) begin
      crc_before_last <= glob_crc;
      last_word       <= wr_data_i;
      if (first) id_ok_q <= (wr_data_i == DEV_ID);
      if (hdr_crc_i && (wr_data_i != ~tbl_crc)) lcrc_q <= 1'b1;
    end
  end

  cfg_status_reg #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_stat (
    .clk_i, .rst_ni, .cold_i(cold_rst_i), .fire_i(fire),
    .id_err_i(~id_ok_q), .lcrc_err_i(lcrc_q), .gcrc_err_i(last_word != ~crc_before_last),
    .rd_addr_i, .done_o(done), .rd_data_o
  );

  p_ignore_outside_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !in_win && !cold_rst_i) |=> $stable(glob_crc) && $stable(tbl_crc));
  p_tbl_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_we && hdr_crc_i) |=> (tbl_crc == CRC_INIT));
  p_frozen_after_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !cold_rst_i) |=> $stable(glob_crc));
endmodule

// File: tb/cfg_image_checker_bench.sv
module cfg_image_checker_bench;
  localparam int AW = 24;
  localparam logic [AW-1:0] BASE = 24'h02_0000;
  localparam int WIN = 40;
  localparam logic [31:0] DEV_ID = 32'h5A17_C0DE;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, hdr = 1'b0, eoi = 1'b0, cold = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = 24'h1;
  logic [31:0] wr_data = '0, rd_data;
  int total = 0, bad = 0, cyc = 0;

  logic [31:0] img [0:63];
  bit          hmark [0:63];

  always #2 clk = ~clk;

  cfg_image_checker #(.ADDR_W(AW), .BASE(BASE), .WIN_WORDS(WIN), .DEV_ID(DEV_ID)) u_cfg_image_checker (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .hdr_crc_i(hdr), .eoi_i(eoi), .cold_rst_i(cold), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog expired: got %0d cycles, expected fewer than 100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [31:0] b_crc(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r = c;
    for (int by = 0; by < 4; by++) begin
      r ^= {24'h0, w[8*by +: 8]};
      for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
    end
    return r;
  endfunction

  // builds img[0..n-1]; returns expected status word
  function automatic logic [31:0] build(input int n, input bit bad_id, input bit bad_hdr,
                                        input bit bad_fin, input bit use_hdr);
    logic [31:0] gc = 32'hFFFF_FFFF, tc = 32'hFFFF_FFFF;
    bit first_h = 1'b1;
    for (int i = 0; i < 64; i++) hmark[i] = 1'b0;
    img[0] = bad_id ? (DEV_ID ^ 32'h0000_0100) : DEV_ID;
    for (int i = 0; i < n - 1; i++) begin
      if (i > 0) begin
        hmark[i] = use_hdr && (i % 5 == 4) && (i < n - 1);
        if (hmark[i]) begin
          img[i] = ~tc;
          if (bad_hdr && first_h) img[i] ^= 32'h8;
          first_h = 1'b0;
        end else img[i] = $urandom;
      end
      if (hmark[i]) tc = 32'hFFFF_FFFF; else tc = b_crc(tc, img[i]);
      gc = b_crc(gc, img[i]);
    end
    img[n-1] = ~gc ^ (bad_fin ? 32'h0001_0000 : 32'h0);
    begin
      bit l = bad_hdr && !first_h;
      return {!(l || bad_id || bad_fin), l, bad_id, bad_fin, 28'h0};
    end
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input bit h);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; hdr = h;
    @(negedge clk);
    wr_valid = 1'b0; hdr = 1'b0;
  endtask

  task automatic pulse_eoi();
    eoi = 1'b1; @(negedge clk); eoi = 1'b0;
  endtask

  task automatic pulse_cold();
    cold = 1'b1; @(negedge clk); cold = 1'b0;
  endtask

  task automatic upload(input int n, input bit noise);
    for (int i = 0; i < n; i++) begin
      wr(BASE + AW'(i), img[i], hmark[i]);
      if (noise) begin
        wr(BASE - 24'h1, $urandom, 1'b1);
        wr(BASE + AW'(WIN), $urandom, 1'b0);
      end
    end
  endtask

  task automatic status(output logic [31:0] s);
    rd_addr = 24'h1; #0.5; s = rd_data;
  endtask

  initial begin
    logic [31:0] e, s;
    int seed_set;
    seed_set = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    status(s); chk("R1 status after reset", s, 32'h0);

    // good image with headers
    e = build(20, 0, 0, 0, 1);
    upload(20, 0);
    status(s); chk("R8 zero before strobe", s, 32'h0);
    pulse_eoi();
    status(s); chk("R5 valid image", s, e);
    chk("R5 expected valid encoding", e, 32'h8000_0000);
    rd_addr = 24'h2; #0.5; chk("R6 other read address", rd_data, 32'h0);
    rd_addr = 24'h0; #0.5; chk("R6 address zero", rd_data, 32'h0);

    // post-done activity ignored
    wr(BASE, 32'h0, 1'b1); wr(BASE + 24'h3, 32'h1234, 1'b1); pulse_eoi();
    status(s); chk("R8 hold after done", s, 32'h8000_0000);

    pulse_cold();
    status(s); chk("R9 cold reset clears", s, 32'h0);

    e = build(12, 1, 0, 0, 1); upload(12, 0); pulse_eoi();
    status(s); chk("R2 id mismatch", s, 32'h2000_0000);
    pulse_cold();

    e = build(12, 0, 0, 1, 0); upload(12, 0); pulse_eoi();
    status(s); chk("R3 bad trailing crc", s, 32'h1000_0000);
    pulse_cold();

    e = build(14, 0, 1, 0, 1); upload(14, 0); pulse_eoi();
    status(s); chk("R4 bad header crc", s, 32'h4000_0000);
    pulse_cold();

    e = build(16, 0, 0, 0, 1); upload(16, 1); pulse_eoi();
    status(s); chk("R7 out-of-window writes ignored", s, 32'h8000_0000);
    pulse_cold();

    // write coinciding with strobe ignored
    e = build(10, 0, 0, 0, 0); upload(10, 0);
    wr_valid = 1'b1; wr_addr = BASE + 24'hA; wr_data = 32'hDEAD_BEEF; eoi = 1'b1;
    @(negedge clk); wr_valid = 1'b0; eoi = 1'b0;
    status(s); chk("R8 write with strobe ignored", s, e);
    pulse_cold();

    // re-arm: good after bad
    e = build(8, 0, 0, 1, 0); upload(8, 0); pulse_eoi(); pulse_cold();
    e = build(8, 0, 0, 0, 0); upload(8, 0); pulse_eoi();
    status(s); chk("R9 re-armed upload judged fresh", s, e);
    pulse_cold();

    for (int t = 0; t < 30; t++) begin
      int n;
      bit bi, bh, bf, uh, nz;
      n  = 3 + int'($urandom % 30);
      bi = ($urandom % 4) == 0; bh = ($urandom % 4) == 0;
      bf = ($urandom % 4) == 0; uh = $urandom % 2; nz = ($urandom % 3) == 0;
      e = build(n, bi, bh, bf, uh);
      upload(n, nz); pulse_eoi();
      status(s); chk("R2 R3 R4 R5 random image", s, e);
      pulse_cold();
      status(s); chk("R9 random clear", s, 32'h0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule